// File: doc/BRIEF.md
# Pseudo-Random Noise Voice

This block is the noise voice of a retro sound unit. A 15-bit linear feedback shift register is stepped by a programmable timer that runs on a CPU-cycle enable. The least significant register bit gates a 4-bit volume onto the amplitude output. The volume comes either from a fixed value in a control register or from a decaying envelope. A length counter silences the voice when it runs out.

Software writes three byte-wide registers through a simple write strobe. The frame sequencer lives outside this block and supplies the quarter-frame and half-frame pulses that clock the envelope and the length counter. A mode bit moves the second feedback tap. This changes the output from long noise into a short, tonal repeating sequence.

Top module: `noise_chan`

## Requirements
- R1: Address 2 bits 3:0 select the step period P in CPU ticks from the list 4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068 (index 0 first). After reset, the first `cpu_tick` steps the register. After that, a step happens once every P ticks. A new index takes effect at the next step.
- R2: The shift register resets to 1 and never holds all zeros.
- R3: On each step the register shifts right by one, and bit 14 takes bit 0 XOR bit 1 when address 2 bit 7 is clear. When that bit is set, bit 14 takes bit 0 XOR bit 6.
- R4: `amp_out` equals the current volume when shift-register bit 0 is 1, and 0 when it is 0.
- R5: The volume is 0 while the length count is 0, and it is 0 after reset. Otherwise it is address 0 bits 3:0 when address 0 bit 4 is set, and the envelope level when that bit is clear.
- R6: A write to address 3 loads the length count with data bits 7:3. A `half_tick` decrements a nonzero count unless address 0 bit 5 (halt) is set. When a load and a `half_tick` fall in the same cycle, the load wins.
- R7: A write to address 3 requests an envelope restart. The next `quarter_tick`, including one in the same cycle as the write, sets the level to 15 and the divider to address 0 bits 3:0. After that, the level drops by one every (address 0 bits 3:0)+1 quarter ticks.
- R8: When the envelope level is 0 and the divider expires, the level stays 0, unless address 0 bit 5 (loop) is set, in which case it returns to 15.
- R9: Writes to address 1, and bus values while `wr_en` is low, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tick | input | 1 | CPU-cycle enable for the period timer |
| quarter_tick | input | 1 | Quarter-frame pulse, clocks the envelope |
| half_tick | input | 1 | Half-frame pulse, clocks the length counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| amp_out | output | 4 | Amplitude output |

## Verification
Two pairs of functions can fall in the same cycle. A write to address 3 can coincide with a `half_tick`, and the same write can coincide with a `quarter_tick`. The bench provokes each pair by issuing the write and the pulse in one clock. It then judges the length load by counting how many further half ticks pass before the output goes silent. It judges the envelope restart by reading a level of 15 straight away, with no further quarter tick.

// File: rtl/noise_pkg.sv
package noise_pkg;
  localparam int LFSR_W = 15;
  localparam int TMR_W  = 12;
  localparam int VOL_W  = 4;
  localparam int LEN_W  = 5;

  typedef logic [TMR_W-1:0] tmr_t;

  function automatic tmr_t step_period(input logic [3:0] idx);
    case (idx)
      4'd0:  step_period = tmr_t'(4);
      4'd1:  step_period = tmr_t'(8);
      4'd2:  step_period = tmr_t'(16);
      4'd3:  step_period = tmr_t'(32);
      4'd4:  step_period = tmr_t'(64);
      4'd5:  step_period = tmr_t'(96);
      4'd6:  step_period = tmr_t'(128);
      4'd7:  step_period = tmr_t'(160);
      4'd8:  step_period = tmr_t'(202);
      4'd9:  step_period = tmr_t'(254);
      4'd10: step_period = tmr_t'(380);
      4'd11: step_period = tmr_t'(508);
      4'd12: step_period = tmr_t'(762);
      4'd13: step_period = tmr_t'(1016);
      4'd14: step_period = tmr_t'(2034);
      default: step_period = tmr_t'(4068);
    endcase
  endfunction
endpackage

// File: rtl/noise_timer.sv
module noise_timer
  import noise_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [3:0] period_idx,
  output logic       step
);
  tmr_t cnt_q, cnt_d;

  assign step = tick_en && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (tick_en) begin
      if (cnt_q == '0) cnt_d = step_period(period_idx) - tmr_t'(1);
      else             cnt_d = cnt_q - tmr_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int W         = 15,
  parameter int LONG_TAP  = 1,
  parameter int SHORT_TAP = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         short_mode,
  output logic [W-1:0] state
);
  logic [W-1:0] st_q, st_d;
  logic         fb;

  assign fb = st_q[0] ^ (short_mode ? st_q[SHORT_TAP] : st_q[LONG_TAP]);

  always_comb begin
    st_d = st_q;
    if (step) st_d = {fb, st_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= {{(W-1){1'b0}}, 1'b1};
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/noise_env.sv
module noise_env #(
  parameter int VW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          quarter,
  input  logic          restart_req,
  input  logic [VW-1:0] div_period,
  input  logic          loop_en,
  output logic [VW-1:0] level,
  output logic          restart_eff
);
  logic          pend_q, pend_d;
  logic [VW-1:0] div_q, div_d, lvl_q, lvl_d;

  assign restart_eff = pend_q | restart_req;

  always_comb begin
    pend_d = pend_q | restart_req;
    div_d  = div_q;
    lvl_d  = lvl_q;
    if (quarter) begin
      if (restart_eff) begin
        pend_d = 1'b0;
        lvl_d  = '1;
        div_d  = div_period;
      end else if (div_q == '0) begin
        div_d = div_period;
        if (lvl_q != '0)  lvl_d = lvl_q - 1'b1;
        else if (loop_en) lvl_d = '1;
      end else begin
        div_d = div_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      div_q  <= '0;
      lvl_q  <= '0;
    end else begin
      pend_q <= pend_d;
      div_q  <= div_d;
      lvl_q  <= lvl_d;
    end
  end

  assign level = lvl_q;
endmodule

// File: rtl/noise_len.sv
module noise_len #(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] load_val,
  input  logic          half,
  input  logic          halt,
  output logic [LW-1:0] count
);
  logic [LW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                              cnt_d = load_val;
    else if (half && !halt && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/noise_chan.sv
module noise_chan
  import noise_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_tick,
  input  logic       quarter_tick,
  input  logic       half_tick,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [3:0] amp_out
);
  localparam int CTRL_W = VOL_W + 2;

  logic [1:0]        rs_q;
  logic              rst_i_n;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [3:0]        idx_q, idx_d;
  logic              mode_q, mode_d;
  logic              wr_ctrl, wr_per, wr_len;
  logic              step;
  logic [LFSR_W-1:0] lfsr;
  logic [VOL_W-1:0]  env_level, vol;
  logic              env_restart_eff;
  logic [LEN_W-1:0]  len_cnt;

  // Reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign wr_ctrl = wr_en && (wr_addr == 2'd0);
  assign wr_per  = wr_en && (wr_addr == 2'd2);
  assign wr_len  = wr_en && (wr_addr == 2'd3);

  always_comb begin
    ctrl_d = ctrl_q;
    idx_d  = idx_q;
    mode_d = mode_q;
    if (wr_ctrl) ctrl_d = wr_data[CTRL_W-1:0];
    if (wr_per) begin
      idx_d  = wr_data[3:0];
      mode_d = wr_data[7];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q <= '0;
      idx_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      idx_q  <= idx_d;
      mode_q <= mode_d;
    end
  end

  noise_timer u_timer (
    .clk(clk), .rst_n(rst_i_n), .tick_en(cpu_tick),
    .period_idx(idx_q), .step(step)
  );

  noise_lfsr #(.W(LFSR_W), .LONG_TAP(1), .SHORT_TAP(6)) u_lfsr (
    .clk(clk), .rst_n(rst_i_n), .step(step),
    .short_mode(mode_q), .state(lfsr)
  );

  noise_env #(.VW(VOL_W)) u_env (
    .clk(clk), .rst_n(rst_i_n), .quarter(quarter_tick),
    .restart_req(wr_len), .div_period(ctrl_q[VOL_W-1:0]),
    .loop_en(ctrl_q[VOL_W+1]), .level(env_level),
    .restart_eff(env_restart_eff)
  );

  noise_len #(.LW(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_i_n), .load(wr_len),
    .load_val(wr_data[7:8-LEN_W]), .half(half_tick),
    .halt(ctrl_q[VOL_W+1]), .count(len_cnt)
  );

  always_comb begin
    if (len_cnt == '0)     vol = '0;
    else if (ctrl_q[VOL_W]) vol = ctrl_q[VOL_W-1:0];
    else                   vol = env_level;
  end

  assign amp_out = lfsr[0] ? vol : '0;
endmodule

// File: rtl/noise_chan_chk.sv
module noise_chan_chk (
  input logic        clk,
  input logic        rst_i_n,
  input logic        step,
  input logic [14:0] lfsr,
  input logic [4:0]  len_cnt,
  input logic        wr_len,
  input logic        half_tick,
  input logic        quarter_tick,
  input logic        env_restart_eff,
  input logic [3:0]  env_level,
  input logic [3:0]  amp_out
);
  a_r2_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_i_n)
    lfsr != '0);

  a_r3_lfsr_shift: assert property (@(posedge clk) disable iff (!rst_i_n)
    step |=> lfsr[13:0] == $past(lfsr[14:1]));

  a_r3_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    !step |=> $stable(lfsr));

  a_r5_silent: assert property (@(posedge clk) disable iff (!rst_i_n)
    len_cnt == '0 |-> amp_out == '0);

  a_r6_len_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!wr_len && !half_tick) |=> $stable(len_cnt));

  a_r7_env_restart: assert property (@(posedge clk) disable iff (!rst_i_n)
    (quarter_tick && env_restart_eff) |=> env_level == 4'hF);
endmodule

bind noise_chan noise_chan_chk i_chk (
  .clk(clk), .rst_i_n(rst_i_n), .step(step), .lfsr(lfsr),
  .len_cnt(len_cnt), .wr_len(wr_len), .half_tick(half_tick),
  .quarter_tick(quarter_tick), .env_restart_eff(env_restart_eff),
  .env_level(env_level), .amp_out(amp_out)
);

// File: tb/test_noise_chan.sv
`timescale 1ns/1ps
module test_noise_chan;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_tick, quarter_tick, half_tick, wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] amp_out;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  noise_chan i_noise_chan (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick),
    .quarter_tick(quarter_tick), .half_tick(half_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .amp_out(amp_out)
  );

  function automatic int per_of(input int idx);
    int tbl[16] = '{4, 8, 16, 32, 64, 96, 128, 160, 202, 254,
                    380, 508, 762, 1016, 2034, 4068};
    return tbl[idx];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at falling edge, release after rising edge
  task automatic cyc(input bit w, input logic [1:0] a, input logic [7:0] d,
                     input bit c, input bit q, input bit h);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d;
    cpu_tick = c; quarter_tick = q; half_tick = h;
    @(posedge clk);
    #1;
    wr_en = 0; cpu_tick = 0; quarter_tick = 0; half_tick = 0;
    wr_addr = 0; wr_data = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(1, a, d, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    wr_en = 0; cpu_tick = 0; quarter_tick = 0; half_tick = 0;
    wr_addr = 0; wr_data = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R5 reset amp", amp_out, 0);
  endtask

  task automatic t_const_volume();
    do_reset();
    wr(2'd0, 8'h17);
    check("R5 length zero silent", amp_out, 0);
    wr(2'd3, 8'h28);
    check("R4 R5 constant volume", amp_out, 7);
    wr(2'd0, 8'h1C);
    check("R5 constant volume update", amp_out, 12);
    wr(2'd1, 8'hFF);
    cyc(0, 2'd0, 8'h00, 0, 0, 0);
    @(negedge clk);
    wr_data = 8'h13; wr_addr = 2'd0;
    @(negedge clk);
    wr_data = 0;
    check("R9 ignored writes", amp_out, 12);
  endtask

  task automatic t_lfsr(input bit mode, input int idx, input int ncyc, input string req);
    logic [14:0] m;
    int cnt;
    int bad;
    int p;
    do_reset();
    wr(2'd0, 8'h19);
    wr(2'd2, {mode, 3'b000, idx[3:0]});
    wr(2'd3, 8'hF8);
    m = 15'd1; cnt = 0; bad = 0; p = per_of(idx);
    for (int i = 0; i < ncyc; i++) begin
      cyc(0, 2'd0, 8'h00, 1, 0, 0);
      if (cnt == 0) begin
        cnt = p - 1;
        m = {m[0] ^ (mode ? m[6] : m[1]), m[14:1]};
      end else cnt--;
      if (amp_out != (m[0] ? 4'd9 : 4'd0)) begin
        if (bad == 0)
          $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, i, amp_out,
                   m[0] ? 9 : 0);
        bad++;
      end
    end
    checks++;
    if (bad != 0) failures++;
  endtask

  task automatic t_period_change();
    logic [14:0] m;
    int cnt;
    int bad;
    do_reset();
    wr(2'd0, 8'h1F);
    wr(2'd3, 8'hF8);
    m = 15'd1; cnt = 0; bad = 0;
    for (int i = 0; i < 300; i++) begin
      if (i == 50) wr(2'd2, 8'h02);
      cyc(0, 2'd0, 8'h00, 1, 0, 0);
      if (cnt == 0) begin
        cnt = ((i < 50) ? 4 : 16) - 1;
        m = {m[0] ^ m[1], m[14:1]};
      end else cnt--;
      if (amp_out != (m[0] ? 4'd15 : 4'd0)) bad++;
    end
    check("R1 index change at next step", bad, 0);
  endtask

  task automatic t_length();
    do_reset();
    wr(2'd0, 8'h1F);
    cyc(1, 2'd3, 8'h18, 0, 0, 1);
    check("R6 load wins over half tick", amp_out, 15);
    cyc(0, 2'd0, 8'h00, 0, 0, 1);
    cyc(0, 2'd0, 8'h00, 0, 0, 1);
    check("R6 count one left", amp_out, 15);
    cyc(0, 2'd0, 8'h00, 0, 0, 1);
    check("R6 expired", amp_out, 0);
    cyc(0, 2'd0, 8'h00, 0, 0, 1);
    check("R6 stays zero", amp_out, 0);
    wr(2'd0, 8'h3F);
    wr(2'd3, 8'h08);
    repeat (5) cyc(0, 2'd0, 8'h00, 0, 0, 1);
    check("R6 halt blocks decrement", amp_out, 15);
  endtask

  task automatic t_env(input bit loop_on);
    do_reset();
    wr(2'd0, loop_on ? 8'h22 : 8'h02);
    wr(2'd3, 8'hF8);
    check("R7 level before restart", amp_out, 0);
    cyc(0, 2'd0, 8'h00, 0, 1, 0);
    check("R7 restart to 15", amp_out, 15);
    repeat (3) cyc(0, 2'd0, 8'h00, 0, 1, 0);
    check("R7 decay every period+1", amp_out, 14);
    repeat (2) cyc(0, 2'd0, 8'h00, 0, 1, 0);
    check("R7 no early decay", amp_out, 14);
    repeat (40) cyc(0, 2'd0, 8'h00, 0, 1, 0);
    check("R7 reaches zero", amp_out, 0);
    repeat (3) cyc(0, 2'd0, 8'h00, 0, 1, 0);
    check(loop_on ? "R8 loop wraps to 15" : "R8 holds at zero", amp_out,
          loop_on ? 15 : 0);
  endtask

  task automatic t_env_same_cycle();
    do_reset();
    wr(2'd0, 8'h00);
    cyc(1, 2'd3, 8'hF8, 0, 1, 0);
    check("R7 restart same cycle as quarter", amp_out, 15);
    cyc(0, 2'd0, 8'h00, 0, 1, 0);
    check("R7 period zero decays each tick", amp_out, 14);
  endtask

  initial begin
    rst_n = 0;
    t_reset();
    t_const_volume();
    t_lfsr(1'b0, 0, 400, "R3 long mode");
    t_lfsr(1'b1, 0, 400, "R3 short mode");
    t_lfsr(1'b0, 3, 600, "R1 period 32");
    t_lfsr(1'b1, 8, 1000, "R1 period 202");
    t_period_change();
    t_length();
    t_env(1'b0);
    t_env(1'b1);
    t_env_same_cycle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule